// File: doc/BRIEF.md
# Sample-Qualified Trigger Conditioner

This block sits between trigger detection and the capture and output logic of a sampled acquisition path. Samples arrive on a valid strobe that may be high every clock or only once every several clocks when the stream is decimated. The block merges an internal trigger event with an external trigger input, applies a programmable holdoff after every accepted trigger, and delays the accepted trigger by a fixed number of valid samples. The delay is there so that the capture path lines up with a companion logic-analyzer path.

External trigger pulses can be shorter than the gap between valid samples. Such a pulse is remembered until the next valid sample consumes it, so no pulse is lost at low sample rates. The delayed trigger also drives a trigger pin through a 20-bit hold counter. Each new pin level, high or low, is kept for the programmed number of clocks before the pin may change again, which keeps short glitches off the pin. At a 50 MHz clock, a hold value of 100000 gives about 2 ms.

Top module: `trig_conditioner`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) drives capTrig and trigPin low and clears all pending trigger, holdoff and hold state.
- R2: A trigger accepted on a valid sample makes capTrig high during the valid sample that comes DELAY_SAMPLES (default 2) valid samples later. This holds whether valid is high every clock or only every few clocks.
- R3: capTrig changes only at a clock edge where sampleValid was high in the cycle before it. Between valid samples it holds its value.
- R4: intTrig counts only in cycles where sampleValid is high. An internal pulse in a cycle with sampleValid low has no effect.
- R5: An extTrig pulse in a cycle with sampleValid low stays pending until the next valid sample, which takes it as a trigger candidate. Each external pulse that lands in a separate sample interval yields exactly one capTrig sample when holdoff is zero.
- R6: After a trigger is accepted with holdoffLen = L, every candidate in the next L clocks is dropped, not queued. A pending external pulse is consumed by a dropped valid sample.
- R7: holdoffClear high in a cycle ends a running holdoff, so a candidate in the following cycle is accepted.
- R8: With holdoffLen = 0 every candidate on a valid sample is accepted, including candidates on back-to-back samples.
- R9: When no hold is running, trigPin takes the value capTrig had in the previous cycle, one clock after capTrig changes.
- R10: After every trigPin transition, in either direction, the new level stays for at least max(holdPeriod, 1) clocks. It stays for exactly holdPeriod clocks when the request has already changed back by then.
- R11: holdPeriod = 0 means no hold: trigPin follows capTrig with a one-clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Sample-valid strobe; also the clock enable of the delay stages |
| intTrig | input | 1 | Internal trigger event from condition evaluation |
| extTrig | input | 1 | External trigger input, may be a single-clock pulse |
| holdoffClear | input | 1 | Ends a running holdoff early |
| holdoffLen | input | HOLDOFF_W (32) | Holdoff length in clocks after an accepted trigger |
| holdPeriod | input | HOLD_W (20) | Minimum clocks each trigPin level is held; 0 = no hold |
| capTrig | output | 1 | Trigger for the capture path, delayed by DELAY_SAMPLES valid samples |
| trigPin | output | 1 | Conditioned trigger output pin |

## Verification
A trigger accepted on a valid sample shows up on capTrig at the second valid sample after it. That is two clocks later when valid is high every clock, and ten clocks later when valid comes every fifth clock. trigPin follows capTrig one clock after that when no hold is running. The bench keeps a per-clock reference model that is updated at each rising edge from the same inputs. It compares both outputs at the following falling edge, so every check sees exactly the registers that were loaded at that edge. The pulse-count checks run enough idle valid samples after the last stimulus for the last trigger to get through both delay stages.

// File: rtl/trigcond_pkg.sv
package trigcond_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic sampleEn;  // a sample is present this cycle
    logic accept;    // a trigger was accepted on this sample
  } ctrlStrb_t;

endpackage

// File: rtl/trigcond_ctrl.sv
module trigcond_ctrl
  import trigcond_pkg::*;
#(
  parameter int HOLDOFF_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sampleValid,
  input  logic                 intTrig,
  input  logic                 extTrig,
  input  logic                 holdoffClear,
  input  logic [HOLDOFF_W-1:0] holdoffLen,
  output ctrlStrb_t            strb
);

  localparam logic [HOLDOFF_W-1:0] HO_ONE = HOLDOFF_W'(1);

  logic                 extPend;
  logic                 extSeen;
  logic                 candidate;
  logic                 hoIdle;
  logic                 accept;
  logic [HOLDOFF_W-1:0] hoCnt;

  // External pulse is remembered until a valid sample takes it
  assign extSeen   = extTrig | extPend;
  assign candidate = sampleValid & (intTrig | extSeen);
  assign hoIdle    = (hoCnt == '0);
  assign accept    = candidate & hoIdle;

  always_ff @(posedge clk) begin
    if (rst) begin
      extPend <= 1'b0;
    end else begin
      extPend <= extSeen & ~sampleValid;
    end
  end

  // Holdoff: loaded on accept, ended early by holdoffClear
  always_ff @(posedge clk) begin
    if (rst) begin
      hoCnt <= '0;
    end else if (accept) begin
      hoCnt <= holdoffLen;
    end else if (holdoffClear) begin
      hoCnt <= '0;
    end else if (!hoIdle) begin
      hoCnt <= hoCnt - HO_ONE;
    end
  end

  assign strb.sampleEn = sampleValid;
  assign strb.accept   = accept;

endmodule

// File: rtl/trigcond_dpath.sv
module trigcond_dpath
  import trigcond_pkg::*;
#(
  parameter int DELAY_SAMPLES = 2,
  parameter int HOLD_W        = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrb_t         strb,
  input  logic [HOLD_W-1:0] holdPeriod,
  output logic              capTrig,
  output logic              trigPin
);

  localparam logic [HOLD_W-1:0] HOLD_ONE = HOLD_W'(1);

  logic [DELAY_SAMPLES-1:0] stage;

  // Delay stages: synchronous reset, sample-valid as clock enable
  if (DELAY_SAMPLES == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst) begin
        stage <= '0;
      end else if (strb.sampleEn) begin
        stage <= strb.accept;
      end
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) begin
        stage <= '0;
      end else if (strb.sampleEn) begin
        stage <= {stage[DELAY_SAMPLES-2:0], strb.accept};
      end
    end
  end

  assign capTrig = stage[DELAY_SAMPLES-1];

  // Output pin: every level is held for the programmed period
  logic [HOLD_W-1:0] holdCnt;
  logic [HOLD_W-1:0] holdLoad;
  logic              holdBusy;

  assign holdLoad = (holdPeriod == '0) ? '0 : (holdPeriod - HOLD_ONE);
  assign holdBusy = (holdCnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      trigPin <= 1'b0;
      holdCnt <= '0;
    end else if (holdBusy) begin
      holdCnt <= holdCnt - HOLD_ONE;
    end else if (capTrig != trigPin) begin
      trigPin <= capTrig;
      holdCnt <= holdLoad;
    end
  end

endmodule

// File: rtl/trig_conditioner.sv
module trig_conditioner
  import trigcond_pkg::*;
#(
  parameter int DELAY_SAMPLES = 2,
  parameter int HOLD_W        = 20,
  parameter int HOLDOFF_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sampleValid,
  input  logic                 intTrig,
  input  logic                 extTrig,
  input  logic                 holdoffClear,
  input  logic [HOLDOFF_W-1:0] holdoffLen,
  input  logic [HOLD_W-1:0]    holdPeriod,
  output logic                 capTrig,
  output logic                 trigPin
);

  ctrlStrb_t ctrlStrb;

  trigcond_ctrl #(
    .HOLDOFF_W(HOLDOFF_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sampleValid (sampleValid),
    .intTrig     (intTrig),
    .extTrig     (extTrig),
    .holdoffClear(holdoffClear),
    .holdoffLen  (holdoffLen),
    .strb        (ctrlStrb)
  );

  trigcond_dpath #(
    .DELAY_SAMPLES(DELAY_SAMPLES),
    .HOLD_W       (HOLD_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strb      (ctrlStrb),
    .holdPeriod(holdPeriod),
    .capTrig   (capTrig),
    .trigPin   (trigPin)
  );

endmodule

// File: rtl/trigcond_checker.sv
module trigcond_checker
  import trigcond_pkg::*;
#(
  parameter int DELAY_SAMPLES = 2,
  parameter int HOLD_W        = 20,
  parameter int HOLDOFF_W     = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 sampleValid,
  input logic                 intTrig,
  input logic                 extTrig,
  input logic [HOLDOFF_W-1:0] holdoffLen,
  input logic [HOLD_W-1:0]    holdPeriod,
  input logic                 capTrig,
  input logic                 trigPin,
  input ctrlStrb_t            strb
);

  // History of accepts, shifted once per valid sample
  logic [DELAY_SAMPLES-1:0] histAcc;
  always_ff @(posedge clk) begin
    if (rst) histAcc <= '0;
    else if (strb.sampleEn) histAcc <= (histAcc << 1) | DELAY_SAMPLES'(strb.accept);
  end

  // Own record of an external pulse waiting for a sample
  logic chkPend;
  always_ff @(posedge clk) begin
    if (rst) chkPend <= 1'b0;
    else chkPend <= (chkPend | extTrig) & ~sampleValid;
  end

  // Pin level age tracking
  logic        prevPin;
  logic        armed;
  logic [31:0] age;
  logic [31:0] need;
  logic        pinChanged;
  assign pinChanged = (trigPin != prevPin);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevPin <= 1'b0;
      armed   <= 1'b0;
      age     <= '0;
      need    <= 32'd1;
    end else begin
      prevPin <= trigPin;
      if (pinChanged) begin
        armed <= 1'b1;
        age   <= 32'd1;
        need  <= (holdPeriod == '0) ? 32'd1 : 32'(holdPeriod);
      end else if (age != 32'hFFFF_FFFF) begin
        age <= age + 32'd1;
      end
    end
  end

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!capTrig && !trigPin));

  assert_delay_R2: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> (capTrig == histAcc[DELAY_SAMPLES-1]));

  assert_sample_edge_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(sampleValid) |-> $stable(capTrig));

  assert_int_qualified_R4: assert property (@(posedge clk) disable iff (rst)
    (intTrig && !sampleValid) |-> !strb.accept);

  assert_ext_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (chkPend && sampleValid && holdoffLen == '0) |-> strb.accept);

  assert_holdoff_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (strb.accept && holdoffLen != '0) |=> !strb.accept);

  assert_pin_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (pinChanged && armed) |-> (age >= need));

endmodule

bind trig_conditioner trigcond_checker #(
  .DELAY_SAMPLES(DELAY_SAMPLES),
  .HOLD_W       (HOLD_W),
  .HOLDOFF_W    (HOLDOFF_W)
) i_trigcond_checker (
  .clk        (clk),
  .rst        (rst),
  .sampleValid(sampleValid),
  .intTrig    (intTrig),
  .extTrig    (extTrig),
  .holdoffLen (holdoffLen),
  .holdPeriod (holdPeriod),
  .capTrig    (capTrig),
  .trigPin    (trigPin),
  .strb       (ctrlStrb)
);

// File: tb/test_trig_conditioner.sv
`timescale 1ns/1ps
module test_trig_conditioner;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleValid = 1'b0;
  logic        intTrig = 1'b0;
  logic        extTrig = 1'b0;
  logic        holdoffClear = 1'b0;
  logic [31:0] holdoffLen = '0;
  logic [19:0] holdPeriod = '0;
  logic        capTrig;
  logic        trigPin;

  always #2 clk = ~clk;  // 250 MHz

  trig_conditioner i_trig_conditioner (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .intTrig(intTrig),
    .extTrig(extTrig), .holdoffClear(holdoffClear), .holdoffLen(holdoffLen),
    .holdPeriod(holdPeriod), .capTrig(capTrig), .trigPin(trigPin)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference model state
  logic        mExtPend, mS1, mCap, mPin;
  logic [31:0] mHoCnt;
  logic [19:0] mHold;
  logic        lastCap;
  int          capHigh;
  string       capTag = "R2";
  string       pinTag = "R9";

  function automatic logic [19:0] holdLoadOf(input logic [19:0] p);
    return (p == 20'd0) ? 20'd0 : p - 20'd1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkCount(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelStep();
    logic cand, acc, capOld;
    cand = sampleValid & (intTrig | extTrig | mExtPend);
    acc  = cand & (mHoCnt == 32'd0);
    mExtPend = (extTrig | mExtPend) & ~sampleValid;
    if (acc) mHoCnt = holdoffLen;
    else if (holdoffClear) mHoCnt = 32'd0;
    else if (mHoCnt != 32'd0) mHoCnt = mHoCnt - 32'd1;
    capOld = mCap;
    if (mHold != 20'd0) mHold = mHold - 20'd1;
    else if (capOld != mPin) begin
      mPin  = capOld;
      mHold = holdLoadOf(holdPeriod);
    end
    if (sampleValid) begin
      mCap = mS1;
      mS1  = acc;
    end
  endtask

  task automatic doReset(input logic [31:0] ho, input logic [19:0] hp);
    rst = 1'b1; holdoffLen = ho; holdPeriod = hp;
    sampleValid = 1'b0; intTrig = 1'b0; extTrig = 1'b0; holdoffClear = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs low after reset edges
    check("R1", capTrig, 1'b0, "capTrig in reset");
    check("R1", trigPin, 1'b0, "trigPin in reset");
    rst = 1'b0;
    mExtPend = 0; mS1 = 0; mCap = 0; mPin = 0; mHoCnt = '0; mHold = '0;
    lastCap = 0; capHigh = 0;
  endtask

  task automatic cycle(input logic v, input logic it, input logic et, input logic hc);
    sampleValid = v; intTrig = it; extTrig = et; holdoffClear = hc;
    if (v && lastCap) capHigh++;  // capTrig seen on a valid sample
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check(capTag, capTrig, mCap, "capTrig");
    check(pinTag, trigPin, mPin, "trigPin");
    if (!v) check("R3", capTrig, lastCap, "capTrig moved without sample");
    lastCap = capTrig;
  endtask

  task automatic idleValid(input int n, input int every);
    for (int k = 0; k < n * every; k++) cycle((k % every) == every - 1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    int expect1, extCount, gap, highRun;
    seedDummy = $urandom(32'h5EED_0042);

    // Phase 1: valid every clock, no holdoff, no hold (R8, R11, R5)
    doReset(32'd0, 20'd0);
    capTag = "R8"; pinTag = "R11";
    expect1 = 0;
    for (int k = 0; k < 400; k++) begin
      logic it, et;
      it = ($urandom % 8) == 0;
      et = ($urandom % 8) == 0;
      if (it || et) expect1++;
      cycle(1'b1, it, et, 1'b0);
    end
    idleValid(4, 1);
    checkCount("R5", capHigh, expect1, "capTrig samples, valid every clock");

    // Phase 2: valid every 5th clock, external pulses only (R2, R5, R9)
    doReset(32'd0, 20'd0);
    capTag = "R2"; pinTag = "R9";
    extCount = 0;
    gap = 0;
    for (int k = 0; k < 1500; k++) begin
      logic et;
      et = 1'b0;
      if (gap == 0) begin
        et = 1'b1;
        extCount++;
        gap = 5 + ($urandom % 7);
      end else gap--;
      cycle((k % 5) == 4, 1'b0, et, 1'b0);
    end
    idleValid(4, 5);
    checkCount("R5", capHigh, extCount, "capTrig samples, valid every fifth clock");

    // Directed R2: one trigger, valid every 5th clock
    capHigh = 0;
    cycle(1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) cycle(1'b0, 1'b0, 1'b0, 1'b0);
    check("R2", capTrig, 1'b0, "capTrig before first delayed sample");
    cycle(1'b1, 1'b0, 1'b0, 1'b0);
    check("R2", capTrig, 1'b1, "capTrig after second sample edge");
    idleValid(3, 5);

    // Directed R4: internal pulse without a sample has no effect
    capHigh = 0;
    cycle(1'b0, 1'b1, 1'b0, 1'b0);
    idleValid(4, 3);
    checkCount("R4", capHigh, 0, "capTrig samples after unqualified internal pulse");

    // Phase 3: holdoff 7 with random clears (R6, R7)
    doReset(32'd7, 20'd0);
    capTag = "R6";
    for (int k = 0; k < 1500; k++)
      cycle(($urandom % 2) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0, ($urandom % 20) == 0);
    idleValid(12, 1);
    capHigh = 0;
    cycle(1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) cycle(1'b1, 1'b1, 1'b0, 1'b0);
    idleValid(10, 1);
    checkCount("R6", capHigh, 1, "triggers inside holdoff dropped");
    capTag = "R7";
    capHigh = 0;
    cycle(1'b1, 1'b1, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 1'b0, 1'b1);
    cycle(1'b1, 1'b1, 1'b0, 1'b0);
    idleValid(10, 1);
    checkCount("R7", capHigh, 2, "trigger after holdoff clear accepted");

    // Phase 4: hold 20, valid every 2nd clock (R10)
    doReset(32'd0, 20'd20);
    capTag = "R2"; pinTag = "R10";
    for (int k = 0; k < 1200; k++) cycle((k % 2) == 1, ($urandom % 30) == 0, 1'b0, 1'b0);

    // Phase 5: long hold 3000, single trigger (R10)
    doReset(32'd0, 20'd3000);
    highRun = 0;
    cycle(1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 7000; k++) begin
      cycle(1'b1, 1'b0, 1'b0, 1'b0);
      if (trigPin) highRun++;
    end
    checkCount("R10", highRun, 3000, "trigPin high run with hold 3000");
    check("R10", trigPin, 1'b0, "trigPin low at end");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule